// File: doc/BRIEF.md
# Priority-Based Reference Clock Selector

This block watches a bank of reference clocks and picks one of them for each of two downstream clock loops, without software. Every reference passes through a synchronizer and has its own monitor. The monitor flags the reference as inactive when no rising edge arrives within a programmable number of local clock cycles. It also counts rising edges over a fixed window of local cycles and accepts the reference only when that count falls between a programmable lower and upper limit. One set of monitors serves both loops.

Each loop has its own priority table, its own selection policy (revertive or nonrevertive), its own revert hold-off and its own integer divider. The selector picks the best eligible reference for its loop. The divider then turns the rising edges of that reference into a one-cycle tick at a lower rate. The tick marks the recovered reference for the loop that follows.

Top module: `refsel_top`

## Requirements
- R1: After reset, `in_valid` is all zero, both `sel_*_vld` flags are low and neither tick output is asserted.
- R2: A reference with no synchronized rising edge for `idle_limit` local cycles has its `in_valid` bit cleared within `idle_limit`+4 cycles of its last rising edge. A reference that timed out must requalify over a full window.
- R3: Measurement windows of `WIN_LEN` local cycles run back to back, starting from reset release. An input is valid only if its rising-edge count in the last window lies within [`cnt_lo`, `cnt_hi`]. An `in_valid` bit can only become set at the end of a window.
- R4: The priority of input i is field `prio_x[i*PRIO_W +: PRIO_W]`. A value of 0 disables the input. Value 1 is the best, and a lower value beats a higher one. Among equal values the lower index wins. When no input is both valid and enabled, `sel_x_vld` is low.
- R5: Loops A and B use only their own priority table, policy bit, hold-off and divider. A change to loop A's table leaves loop B's selection unchanged.
- R6: When the current selection stops being eligible (invalid or priority 0), the loop moves to the best eligible input on the next clock edge, with no hold-off.
- R7: With `revert_x` = 0, the current selection is kept for as long as it stays eligible, even while a better input is valid.
- R8: With `revert_x` = 1, a strictly better input replaces a still-eligible selection only after it has been the best candidate for `holdoff_x` consecutive cycles. The switch happens `holdoff_x`+1 cycles after the candidate first appears in `in_valid`, and not earlier.
- R9: `tick_x` pulses for one cycle on every `div_x`-th synchronized rising edge of the selected input. A `div_x` value of 0 behaves as 1. The edge count restarts when the selection changes, and there are no ticks when nothing is selected.
- R10: If, at one window end, the current selection fails its frequency check and a better input passes, the loop moves straight to that better input on the next edge, even in revertive mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_in | input | 8 | Reference clocks, asynchronous to clk |
| idle_limit | input | 16 | Activity timeout in local cycles |
| cnt_lo | input | 9 | Lowest accepted edge count per window |
| cnt_hi | input | 9 | Highest accepted edge count per window |
| prio_a | input | 24 | Loop A priority table, 3 bits per input |
| prio_b | input | 24 | Loop B priority table, 3 bits per input |
| revert_a | input | 1 | Loop A policy: 1 revertive, 0 nonrevertive |
| revert_b | input | 1 | Loop B policy: 1 revertive, 0 nonrevertive |
| holdoff_a | input | 16 | Loop A revert hold-off in cycles |
| holdoff_b | input | 16 | Loop B revert hold-off in cycles |
| div_a | input | 8 | Loop A divide ratio |
| div_b | input | 8 | Loop B divide ratio |
| in_valid | output | 8 | Per-input validity (active and in frequency) |
| sel_a_vld | output | 1 | Loop A has a selection |
| sel_a_idx | output | 3 | Loop A selected input |
| tick_a | output | 1 | Loop A divided reference tick |
| sel_b_vld | output | 1 | Loop B has a selection |
| sel_b_idx | output | 3 | Loop B selected input |
| tick_b | output | 1 | Loop B divided reference tick |

## Verification
Two events can land on the same cycle: the frequency check of the current selection failing, and the qualification of a better input at the same window end. That same cycle is also the point where the revert hold-off and the failover path compete. The bench provokes it by counting cycles from reset release and changing the rates of both references just after a window boundary, so that the next boundary decides both of them. It then requires the valid bits to flip on the same cycle and the loop to land on the better input one edge later, with no hold-off wait.

// File: rtl/refsel_pkg.sv
package refsel_pkg;
  localparam int NUM_LOOPS = 2;

  typedef enum logic [1:0] {
    ACT_KEEP     = 2'd0,
    ACT_FAILOVER = 2'd1,
    ACT_WAIT     = 2'd2,
    ACT_REVERT   = 2'd3
  } pick_act_e;
endpackage

// File: rtl/refsel_win.sv
module refsel_win #(
  parameter int WIN_LEN = 256,
  localparam int WIN_W = $clog2(WIN_LEN)
) (
  input  logic clk,
  input  logic rst_n,
  output logic end_o
);
  logic [WIN_W-1:0] cnt_q, cnt_n;

  always_comb begin
    end_o = (cnt_q == WIN_W'(WIN_LEN - 1));
    cnt_n = end_o ? '0 : cnt_q + WIN_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  // R3: windows are never shorter than two cycles
  assert_window_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    end_o |=> !end_o);
endmodule

// File: rtl/refsel_mon.sv
module refsel_mon #(
  parameter int TO_W  = 16,
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_i,
  input  logic             win_end_i,
  input  logic [TO_W-1:0]  idle_limit_i,
  input  logic [CNT_W-1:0] cnt_lo_i,
  input  logic [CNT_W-1:0] cnt_hi_i,
  output logic             rise_o,
  output logic             valid_o
);
  logic [2:0]       sync_q;
  logic [TO_W-1:0]  idle_q, idle_n;
  logic [CNT_W-1:0] edges_q, edges_n, edges_sum;
  logic             active_q, active_n;
  logic             fok_q, fok_n;

  always_comb begin
    rise_o    = sync_q[1] & ~sync_q[2];
    if (rise_o)                      idle_n = '0;
    else if (idle_q >= idle_limit_i) idle_n = idle_q;
    else                             idle_n = idle_q + TO_W'(1);
    active_n  = (idle_n < idle_limit_i);
    edges_sum = edges_q + CNT_W'(rise_o);
    edges_n   = win_end_i ? '0 : edges_sum;
    if (!active_n)      fok_n = 1'b0;
    else if (win_end_i) fok_n = (edges_sum >= cnt_lo_i) && (edges_sum <= cnt_hi_i);
    else                fok_n = fok_q;
    valid_o   = active_q & fok_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q   <= '0;
      idle_q   <= '0;
      edges_q  <= '0;
      active_q <= 1'b0;
      fok_q    <= 1'b0;
    end else begin
      sync_q   <= {sync_q[1:0], ref_i};
      idle_q   <= idle_n;
      edges_q  <= edges_n;
      active_q <= active_n;
      fok_q    <= fok_n;
    end
  end

  // R3: qualification only appears at a window boundary
  assert_qualify_at_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid_o) |-> $past(win_end_i));

  // R2: a reference idle past the limit is never reported valid
  assert_idle_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(idle_limit_i) && idle_q >= idle_limit_i) |-> !valid_o);
endmodule

// File: rtl/refsel_pick.sv
module refsel_pick
  import refsel_pkg::*;
#(
  parameter int N_IN   = 8,
  parameter int PRIO_W = 3,
  parameter int HOLD_W = 16,
  localparam int IDX_W = $clog2(N_IN)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N_IN-1:0]        valid_i,
  input  logic [N_IN*PRIO_W-1:0] prio_i,
  input  logic                   revert_i,
  input  logic [HOLD_W-1:0]      holdoff_i,
  output logic                   sel_vld_o,
  output logic [IDX_W-1:0]       sel_idx_o
);
  logic [N_IN-1:0]   elig_v;
  logic              best_found;
  logic [IDX_W-1:0]  best_idx;
  logic [PRIO_W-1:0] best_prio, cur_prio;
  logic              cur_elig, better;
  pick_act_e         act;

  logic              cur_vld_q, cur_vld_n;
  logic [IDX_W-1:0]  cur_idx_q, cur_idx_n;
  logic              hold_vld_q, hold_vld_n;
  logic [IDX_W-1:0]  hold_idx_q, hold_idx_n;
  logic [HOLD_W-1:0] hold_cnt_q, hold_cnt_n;

  // candidate scan: strict compare keeps the lower index on ties
  always_comb begin
    best_found = 1'b0;
    best_idx   = '0;
    best_prio  = '0;
    for (int i = 0; i < N_IN; i++) begin
      elig_v[i] = valid_i[i] & (|prio_i[i*PRIO_W +: PRIO_W]);
      if (elig_v[i] && (!best_found || prio_i[i*PRIO_W +: PRIO_W] < best_prio)) begin
        best_found = 1'b1;
        best_idx   = IDX_W'(i);
        best_prio  = prio_i[i*PRIO_W +: PRIO_W];
      end
    end
  end

  always_comb begin
    cur_prio = prio_i[cur_idx_q*PRIO_W +: PRIO_W];
    cur_elig = cur_vld_q & elig_v[cur_idx_q];
    better   = best_found && (best_prio < cur_prio);
    if (!cur_elig)
      act = ACT_FAILOVER;
    else if (revert_i && better)
      act = (hold_vld_q && hold_idx_q == best_idx && hold_cnt_q >= holdoff_i) ? ACT_REVERT : ACT_WAIT;
    else
      act = ACT_KEEP;
  end

  always_comb begin
    cur_vld_n  = cur_vld_q;
    cur_idx_n  = cur_idx_q;
    hold_vld_n = 1'b0;
    hold_idx_n = hold_idx_q;
    hold_cnt_n = '0;
    case (act)
      ACT_FAILOVER: begin
        cur_vld_n = best_found;
        if (best_found) cur_idx_n = best_idx;
      end
      ACT_REVERT: cur_idx_n = best_idx;
      ACT_WAIT: begin
        hold_vld_n = 1'b1;
        hold_idx_n = best_idx;
        if (hold_vld_q && hold_idx_q == best_idx)
          hold_cnt_n = (hold_cnt_q == '1) ? hold_cnt_q : hold_cnt_q + HOLD_W'(1);
        else
          hold_cnt_n = HOLD_W'(1);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_vld_q  <= 1'b0;
      cur_idx_q  <= '0;
      hold_vld_q <= 1'b0;
      hold_idx_q <= '0;
      hold_cnt_q <= '0;
    end else begin
      cur_vld_q  <= cur_vld_n;
      cur_idx_q  <= cur_idx_n;
      hold_vld_q <= hold_vld_n;
      hold_idx_q <= hold_idx_n;
      hold_cnt_q <= hold_cnt_n;
    end
  end

  assign sel_vld_o = cur_vld_q;
  assign sel_idx_o = cur_idx_q;

  // R4: nothing eligible leaves the loop without a selection
  assert_none_eligible_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(|elig_v) |-> !cur_vld_q);

  // R6: a lost selection is replaced by the best candidate at once
  assert_failover_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!cur_elig) && $past(best_found)) |-> (cur_vld_q && cur_idx_q == $past(best_idx)));

  // R7: nonrevertive keeps an eligible selection
  assert_nonrev_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!revert_i) && $past(cur_elig)) |-> (cur_vld_q && $stable(cur_idx_q)));

  // R8: leaving an eligible selection requires revert mode and an expired hold-off
  assert_revert_wait_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cur_elig) && cur_idx_q != $past(cur_idx_q))
      |-> ($past(revert_i) && $past(hold_cnt_q) >= $past(holdoff_i)));
endmodule

// File: rtl/refsel_div.sv
module refsel_div #(
  parameter int N_IN  = 8,
  parameter int DIV_W = 8,
  localparam int IDX_W = $clog2(N_IN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_IN-1:0]  rise_i,
  input  logic             sel_vld_i,
  input  logic [IDX_W-1:0] sel_idx_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q, cnt_n, last;
  logic             vld_q;
  logic [IDX_W-1:0] idx_q;
  logic             tick_q, tick_n;
  logic             edge_sel, chg;

  always_comb begin
    edge_sel = sel_vld_i & rise_i[sel_idx_i];
    chg      = (sel_vld_i != vld_q) || (sel_idx_i != idx_q);
    last     = (div_i == '0) ? '0 : div_i - DIV_W'(1);
    cnt_n    = cnt_q;
    tick_n   = 1'b0;
    if (chg) begin
      cnt_n = '0;
    end else if (edge_sel) begin
      if (cnt_q >= last) begin
        cnt_n  = '0;
        tick_n = 1'b1;
      end else begin
        cnt_n = cnt_q + DIV_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      vld_q  <= 1'b0;
      idx_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_n;
      vld_q  <= sel_vld_i;
      idx_q  <= sel_idx_i;
      tick_q <= tick_n;
    end
  end

  assign tick_o = tick_q;

  // R9: every tick follows an edge of the selected reference
  assert_tick_on_edge_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tick_q |-> $past(edge_sel));
endmodule

// File: rtl/refsel_top.sv
module refsel_top
  import refsel_pkg::*;
#(
  parameter int N_IN    = 8,
  parameter int PRIO_W  = 3,
  parameter int TO_W    = 16,
  parameter int WIN_LEN = 256,
  parameter int HOLD_W  = 16,
  parameter int DIV_W   = 8,
  localparam int IDX_W  = $clog2(N_IN),
  localparam int CNT_W  = $clog2(WIN_LEN + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N_IN-1:0]        ref_in,
  input  logic [TO_W-1:0]        idle_limit,
  input  logic [CNT_W-1:0]       cnt_lo,
  input  logic [CNT_W-1:0]       cnt_hi,
  input  logic [N_IN*PRIO_W-1:0] prio_a,
  input  logic [N_IN*PRIO_W-1:0] prio_b,
  input  logic                   revert_a,
  input  logic                   revert_b,
  input  logic [HOLD_W-1:0]      holdoff_a,
  input  logic [HOLD_W-1:0]      holdoff_b,
  input  logic [DIV_W-1:0]       div_a,
  input  logic [DIV_W-1:0]       div_b,
  output logic [N_IN-1:0]        in_valid,
  output logic                   sel_a_vld,
  output logic [IDX_W-1:0]       sel_a_idx,
  output logic                   tick_a,
  output logic                   sel_b_vld,
  output logic [IDX_W-1:0]       sel_b_idx,
  output logic                   tick_b
);
  logic                   win_end;
  logic [N_IN-1:0]        rise_v, valid_v;
  logic [N_IN*PRIO_W-1:0] prio_l    [NUM_LOOPS];
  logic                   revert_l  [NUM_LOOPS];
  logic [HOLD_W-1:0]      holdoff_l [NUM_LOOPS];
  logic [DIV_W-1:0]       div_l     [NUM_LOOPS];
  logic                   vld_l     [NUM_LOOPS];
  logic [IDX_W-1:0]       idx_l     [NUM_LOOPS];
  logic                   tick_l    [NUM_LOOPS];

  refsel_win #(.WIN_LEN(WIN_LEN)) u_win (
    .clk(clk), .rst_n(rst_n), .end_o(win_end)
  );

  for (genvar g = 0; g < N_IN; g++) begin : g_mon
    refsel_mon #(.TO_W(TO_W), .CNT_W(CNT_W)) u_mon (
      .clk(clk), .rst_n(rst_n), .ref_i(ref_in[g]), .win_end_i(win_end),
      .idle_limit_i(idle_limit), .cnt_lo_i(cnt_lo), .cnt_hi_i(cnt_hi),
      .rise_o(rise_v[g]), .valid_o(valid_v[g])
    );
  end

  assign prio_l[0]    = prio_a;
  assign prio_l[1]    = prio_b;
  assign revert_l[0]  = revert_a;
  assign revert_l[1]  = revert_b;
  assign holdoff_l[0] = holdoff_a;
  assign holdoff_l[1] = holdoff_b;
  assign div_l[0]     = div_a;
  assign div_l[1]     = div_b;

  for (genvar l = 0; l < NUM_LOOPS; l++) begin : g_loop
    refsel_pick #(.N_IN(N_IN), .PRIO_W(PRIO_W), .HOLD_W(HOLD_W)) u_pick (
      .clk(clk), .rst_n(rst_n), .valid_i(valid_v), .prio_i(prio_l[l]),
      .revert_i(revert_l[l]), .holdoff_i(holdoff_l[l]),
      .sel_vld_o(vld_l[l]), .sel_idx_o(idx_l[l])
    );
    refsel_div #(.N_IN(N_IN), .DIV_W(DIV_W)) u_div (
      .clk(clk), .rst_n(rst_n), .rise_i(rise_v), .sel_vld_i(vld_l[l]),
      .sel_idx_i(idx_l[l]), .div_i(div_l[l]), .tick_o(tick_l[l])
    );
  end

  assign in_valid  = valid_v;
  assign sel_a_vld = vld_l[0];
  assign sel_a_idx = idx_l[0];
  assign tick_a    = tick_l[0];
  assign sel_b_vld = vld_l[1];
  assign sel_b_idx = idx_l[1];
  assign tick_b    = tick_l[1];
endmodule

// File: tb/refsel_top_tb.sv
`timescale 1ns/1ps
module refsel_top_tb;
  logic        clk;
  logic        rst_n;
  logic [7:0]  ref_in;
  logic [15:0] idle_limit;
  logic [8:0]  cnt_lo, cnt_hi;
  logic [23:0] prio_a, prio_b;
  logic        revert_a, revert_b;
  logic [15:0] holdoff_a, holdoff_b;
  logic [7:0]  div_a, div_b;
  logic [7:0]  in_valid;
  logic        sel_a_vld, sel_b_vld, tick_a, tick_b;
  logic [2:0]  sel_a_idx, sel_b_idx;

  int half_ns [8];
  int errors = 0;
  int checks = 0;
  int cyc;

  refsel_top u_dut (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .idle_limit(idle_limit),
    .cnt_lo(cnt_lo), .cnt_hi(cnt_hi), .prio_a(prio_a), .prio_b(prio_b),
    .revert_a(revert_a), .revert_b(revert_b), .holdoff_a(holdoff_a),
    .holdoff_b(holdoff_b), .div_a(div_a), .div_b(div_b), .in_valid(in_valid),
    .sel_a_vld(sel_a_vld), .sel_a_idx(sel_a_idx), .tick_a(tick_a),
    .sel_b_vld(sel_b_vld), .sel_b_idx(sel_b_idx), .tick_b(tick_b)
  );

  initial begin
    clk = 1'b0;
    forever #5 clk = ~clk;
  end

  for (genvar g = 0; g < 8; g++) begin : g_ref
    logic r;
    initial begin
      r = 1'b0;
      forever begin
        if (half_ns[g] == 0) #5;
        else begin
          #(half_ns[g]);
          r = ~r;
        end
      end
    end
    assign ref_in[g] = r;
  end

  always @(posedge clk or negedge rst_n)
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;

  task automatic check_eq(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_rng(input string req, input int act, input int lo, input int hi);
    checks++;
    if (act < lo || act > hi) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic wait_in(input int idx, input logic lvl, input int max_cyc, input string req);
    int n = 0;
    while (in_valid[idx] !== lvl && n < max_cyc) begin
      @(negedge clk);
      n++;
    end
    check_eq(req, int'(in_valid[idx]), int'(lvl));
  endtask

  task automatic count_ticks(input int n, output int ca, output int cb);
    ca = 0;
    cb = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (tick_a) ca++;
      if (tick_b) cb++;
    end
  endtask

  // R1: reset state
  task automatic t_reset();
    check_eq("R1 in_valid", int'(in_valid), 0);
    check_eq("R1 sel vld", int'({sel_a_vld, sel_b_vld}), 0);
    check_eq("R1 ticks", int'({tick_a, tick_b}), 0);
  endtask

  // R3 frequency screening, R4 best pick, R5 tie in table B
  task automatic t_select();
    repeat (700) @(negedge clk);
    check_eq("R3 valid set", int'(in_valid), 8'h27);
    check_eq("R4 loop A pick", int'({sel_a_vld, sel_a_idx}), 4'hD);
    check_eq("R5 loop B tie pick", int'({sel_b_vld, sel_b_idx}), 4'h8);
  endtask

  // R9 divider: 1600 cycles of an 8-cycle reference give 200 edges
  task automatic t_divider();
    int ca, cb;
    count_ticks(1600, ca, cb);
    check_rng("R9 div 4 ticks", ca, 49, 51);
    check_rng("R9 div 0 ticks", cb, 199, 201);
  endtask

  // R2 activity timeout, R6 failover
  task automatic t_failover();
    half_ns[5] = 0;
    repeat (110) @(negedge clk);
    check_eq("R2 stopped input", int'(in_valid[5]), 0);
    check_eq("R6 failover pick", int'({sel_a_vld, sel_a_idx}), 4'hA);
  endtask

  // R7 nonrevertive keeps selection
  task automatic t_nonrevert();
    revert_a = 1'b0;
    half_ns[5] = 40;
    wait_in(5, 1'b1, 800, "R3 requalify");
    repeat (1000) @(negedge clk);
    check_eq("R7 nonrevertive keep", int'({sel_a_vld, sel_a_idx}), 4'hA);
  endtask

  // R8 revertive hold-off
  task automatic t_revert();
    half_ns[5] = 0;
    wait_in(5, 1'b0, 200, "R2 drop");
    revert_a  = 1'b1;
    holdoff_a = 16'd500;
    half_ns[5] = 40;
    wait_in(5, 1'b1, 800, "R3 requalify");
    repeat (490) @(negedge clk);
    check_eq("R8 not before hold-off", int'({sel_a_vld, sel_a_idx}), 4'hA);
    repeat (20) @(negedge clk);
    check_eq("R8 after hold-off", int'({sel_a_vld, sel_a_idx}), 4'hD);
  endtask

  // R4 zero priority disables, R6 immediate move, R5 other loop untouched
  task automatic t_disable();
    prio_a[15 +: 3] = 3'd0;
    @(negedge clk);
    check_eq("R6 disabled moves", int'({sel_a_vld, sel_a_idx}), 4'hA);
    check_eq("R5 loop B unchanged", int'({sel_b_vld, sel_b_idx}), 4'h8);
  endtask

  // R10 loss of current and gain of better input at one window end
  task automatic t_simul();
    int n = 0;
    while ((cyc % 256) != 2 && n < 300) begin
      @(negedge clk);
      n++;
    end
    half_ns[2] = 80;
    half_ns[3] = 40;
    wait_in(2, 1'b0, 600, "R10 current fails");
    check_eq("R10 better valid same cycle", int'(in_valid[3]), 1);
    @(negedge clk);
    check_eq("R10 direct move", int'({sel_a_vld, sel_a_idx}), 4'hB);
  endtask

  // R2/R4/R9 with every reference stopped
  task automatic t_lost();
    int ca, cb;
    for (int i = 0; i < 8; i++) half_ns[i] = 0;
    repeat (115) @(negedge clk);
    check_eq("R2 all dropped", int'(in_valid), 0);
    check_eq("R4 loop A empty", int'(sel_a_vld), 0);
    check_eq("R4 loop B empty", int'(sel_b_vld), 0);
    count_ticks(50, ca, cb);
    check_eq("R9 no ticks", ca + cb, 0);
  endtask

  initial begin
    #1_900_000;
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    half_ns = '{40, 40, 40, 20, 80, 40, 0, 0};
    rst_n      = 1'b0;
    idle_limit = 16'd100;
    cnt_lo     = 9'd28;
    cnt_hi     = 9'd36;
    prio_a     = '0;
    prio_a[15 +: 3] = 3'd1;
    prio_a[6 +: 3]  = 3'd3;
    prio_a[9 +: 3]  = 3'd2;
    prio_b     = '0;
    prio_b[0 +: 3]  = 3'd2;
    prio_b[3 +: 3]  = 3'd2;
    prio_b[12 +: 3] = 3'd1;
    revert_a   = 1'b0;
    revert_b   = 1'b0;
    holdoff_a  = 16'd0;
    holdoff_b  = 16'd0;
    div_a      = 8'd4;
    div_b      = 8'd0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_select();
    t_divider();
    t_failover();
    t_nonrevert();
    t_revert();
    t_disable();
    t_simul();
    t_lost();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule